// File: doc/BRIEF.md
# Bus Identifier Arbitration Node

This block carries one node through the identifier arbitration phase of a CAN-style shared bus. The bus is wired-AND: a driven 0 (dominant) always overrides a 1 (recessive). A start pulse loads an 11-bit identifier. On each bit-time strobe the block samples the resolved bus level against the bit it is driving, and then moves on to the next bit. Bits go out most significant first.

A node that drives recessive but reads dominant has lost to a numerically lower identifier. It stops driving and holds the line recessive for the rest of the field, so the frame of the winner is not disturbed. It reports the index of the bit where it lost. A node that drives dominant but reads recessive has seen a bus fault, not a loss, and flags a bit error. A node that gets through all eleven bits with no mismatch reports a win. Bit timing, stuffing, the fields that follow the identifier, and error framing are handled elsewhere.

Top module: `can_arb_node`

## Requirements
- R1: A start pulse while idle loads the identifier. In the next cycle busy_o=1, tx_o equals identifier bit 10 (the MSB), and won_o, lost_o, bit_err_o and lost_idx_o are cleared to 0.
- R2: Bits go out MSB first. tx_o moves to the next lower identifier bit in the cycle after a strobe on which the bit matched. Between strobes it holds its value.
- R3: A strobe on which the bus level equals the driven bit sets no flag, and arbitration goes on to the next bit.
- R4: A strobe on which tx_o=1 and the bus reads 0 gives, in the next cycle, lost_o=1, tx_o=1, and lost_idx_o equal to the index of that bit. Indices count from 10 at the MSB down to 0 at the LSB.
- R5: After a loss, tx_o stays 1 and rx_only_o=1 while busy_o stays 1 until the strobe for bit 0. busy_o and rx_only_o fall in the cycle after that strobe. A loss on bit 0 ends the field at once.
- R6: After the strobe for bit 0 with no mismatch on any bit, won_o=1, busy_o=0 and tx_o=1 in the next cycle. won_o and lost_o are never 1 together.
- R7: The numerically lowest identifier wins. Against 0x2A3, the identifier 0x2A5 loses with lost_idx_o=2.
- R8: A strobe on which tx_o=0 and the bus reads 1 gives, in the next cycle, bit_err_o=1, tx_o=1, busy_o=0 and lost_o=0.
- R9: A start pulse while busy_o=1 is ignored. The bits driven and the outcome come from the identifier loaded first.
- R10: After synchronous reset: tx_o=1, busy_o=0, rx_only_o=0, won_o=0, lost_o=0, lost_idx_o=0, bit_err_o=0.
- R11: While idle, a strobe has no effect: tx_o stays 1 and the outcome flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to load id_i and begin arbitration |
| id_i | input | ID_W (11) | Identifier to arbitrate with |
| bit_tick_i | input | 1 | One-cycle bit-time strobe; the bus is sampled in this cycle |
| bus_rx_i | input | 1 | Resolved bus level read back |
| tx_o | output | 1 | Level this node drives (1 = recessive) |
| busy_o | output | 1 | Arbitration field in progress |
| rx_only_o | output | 1 | Lost; listening only until the field ends |
| won_o | output | 1 | All identifier bits sent with no loss |
| lost_o | output | 1 | Arbitration lost |
| lost_idx_o | output | IDX_W (4) | Index of the bit where the loss happened |
| bit_err_o | output | 1 | Dominant driven but recessive read |

## Verification
Each internal register shows up at the ports within one strobe. A shift register that slips a bit puts the wrong level on tx_o at the next bit time. A bit counter that is off by one shows a wrong lost_idx_o, or makes busy_o fall a strobe early or late. A wrong state after a loss shows up as tx_o going dominant while rx_only_o is set. The bench runs a behavioural model of the node together with several competing transmitters, resolves the bus as a wired-AND, and compares every output on every clock. A fault therefore shows up in the first cycle after the strobe that exposes it.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_RXO  = 2'd2
  } arb_state_t;

  typedef enum logic [1:0] {
    BIT_MATCH = 2'd0,
    BIT_LOST  = 2'd1,
    BIT_FAULT = 2'd2
  } bit_verdict_t;
endpackage

// File: rtl/can_arb_idshift.sv
// Holds the identifier bits that remain to be sent; the bit being sent sits in the tx register.
module can_arb_idshift #(
  parameter int ID_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [ID_W-1:0] id,
  input  logic            shift,
  output logic            nxt_bit
);
  localparam int REM_W = ID_W - 1;

  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '1;
    end else if (load) begin
      rem_q <= id[REM_W-1:0];
    end else if (shift) begin
      rem_q <= {rem_q[REM_W-2:0], 1'b1};
    end
  end

  assign nxt_bit = rem_q[REM_W-1];
endmodule

// File: rtl/can_arb_bitcnt.sv
// Down counter for the index of the bit being arbitrated (ID_W-1 .. 0).
module can_arb_bitcnt #(
  parameter int ID_W  = 11,
  parameter int IDX_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             dec,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ID_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (load) begin
      idx <= TOP_IDX;
    end else if (dec && idx != '0) begin
      idx <= idx - 1'b1;
    end
  end

  assign at_last = (idx == '0);

  // R4: the bit index never leaves the identifier range
  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    idx <= TOP_IDX);

  // R2: a decrement request moves the index down by exactly one
  p_idx_steps_r2: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && idx != '0) |=> (idx == $past(idx) - 1'b1));
endmodule

// File: rtl/can_arb_judge.sv
// Sorts one bit time into: match, lost (sent 1 read 0), or fault (sent 0 read 1).
module can_arb_judge
  import can_arb_pkg::*;
(
  input  logic         sent_bit,
  input  logic         read_bit,
  output bit_verdict_t verdict
);
  always_comb begin
    if (sent_bit && !read_bit) begin
      verdict = BIT_LOST;
    end else if (!sent_bit && read_bit) begin
      verdict = BIT_FAULT;
    end else begin
      verdict = BIT_MATCH;
    end
  end
endmodule

// File: rtl/can_arb_node.sv
module can_arb_node
  import can_arb_pkg::*;
#(
  parameter int ID_W  = 11,
  parameter int IDX_W = $clog2(ID_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             bit_tick_i,
  input  logic             bus_rx_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             rx_only_o,
  output logic             won_o,
  output logic             lost_o,
  output logic [IDX_W-1:0] lost_idx_o,
  output logic             bit_err_o
);
  arb_state_t       state_q;
  bit_verdict_t     verdict;
  logic             nxt_bit;
  logic [IDX_W-1:0] cur_idx;
  logic             at_last;
  logic             accept;
  logic             arb_tick;
  logic             rxo_tick;
  logic             do_shift;
  logic             do_dec;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign arb_tick = bit_tick_i && (state_q == ST_ARB);
  assign rxo_tick = bit_tick_i && (state_q == ST_RXO);
  assign do_shift = arb_tick && (verdict == BIT_MATCH) && !at_last;
  assign do_dec   = (arb_tick && (verdict != BIT_FAULT)) || rxo_tick;

  can_arb_idshift #(.ID_W(ID_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .id      (id_i),
    .shift   (do_shift),
    .nxt_bit (nxt_bit)
  );

  can_arb_bitcnt #(.ID_W(ID_W), .IDX_W(IDX_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .dec     (do_dec),
    .idx     (cur_idx),
    .at_last (at_last)
  );

  can_arb_judge u_judge (
    .sent_bit (tx_o),
    .read_bit (bus_rx_i),
    .verdict  (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tx_o       <= 1'b1;
      busy_o     <= 1'b0;
      rx_only_o  <= 1'b0;
      won_o      <= 1'b0;
      lost_o     <= 1'b0;
      lost_idx_o <= '0;
      bit_err_o  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q    <= ST_ARB;
            tx_o       <= id_i[ID_W-1];
            busy_o     <= 1'b1;
            won_o      <= 1'b0;
            lost_o     <= 1'b0;
            lost_idx_o <= '0;
            bit_err_o  <= 1'b0;
          end
        end
        ST_ARB: begin
          if (bit_tick_i) begin
            case (verdict)
              BIT_LOST: begin
                lost_o     <= 1'b1;
                lost_idx_o <= cur_idx;
                tx_o       <= 1'b1;
                if (at_last) begin
                  state_q <= ST_IDLE;
                  busy_o  <= 1'b0;
                end else begin
                  state_q   <= ST_RXO;
                  rx_only_o <= 1'b1;
                end
              end
              BIT_FAULT: begin
                bit_err_o <= 1'b1;
                tx_o      <= 1'b1;
                state_q   <= ST_IDLE;
                busy_o    <= 1'b0;
              end
              default: begin
                if (at_last) begin
                  won_o   <= 1'b1;
                  tx_o    <= 1'b1;
                  state_q <= ST_IDLE;
                  busy_o  <= 1'b0;
                end else begin
                  tx_o <= nxt_bit;
                end
              end
            endcase
          end
        end
        ST_RXO: begin
          if (bit_tick_i && at_last) begin
            state_q   <= ST_IDLE;
            busy_o    <= 1'b0;
            rx_only_o <= 1'b0;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          tx_o    <= 1'b1;
          busy_o  <= 1'b0;
        end
      endcase
    end
  end

  // R5: a node that has lost never drives dominant
  p_rxonly_recessive_r5: assert property (@(posedge clk) disable iff (rst)
    rx_only_o |-> tx_o);

  // R6: the two outcomes are exclusive
  p_outcome_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(won_o && lost_o));

  // R4: recessive sent, dominant read -> back off and report
  p_loss_reaction_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !rx_only_o && bit_tick_i && tx_o && !bus_rx_i) |=> (lost_o && tx_o));

  // R8: dominant sent, recessive read -> bit error, not a loss
  p_fault_reaction_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !rx_only_o && bit_tick_i && !tx_o && bus_rx_i) |=> (bit_err_o && !busy_o && !lost_o && tx_o));

  // R2: the driven level only moves on a strobe
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !bit_tick_i) |=> $stable(tx_o));

  // R9: a start while busy neither ends nor restarts the field
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !bit_tick_i) |=> (busy_o && $stable(lost_idx_o) && $stable(rx_only_o)));

  // R11: idle strobes leave the line recessive and the node idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> (tx_o && !busy_o));
endmodule

// File: tb/can_arb_node_bench.sv
`timescale 1ns/1ps
module can_arb_node_bench;
  localparam int ID_W  = 11;
  localparam int IDX_W = 4;
  localparam int NC    = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst;
  logic             start_i;
  logic [ID_W-1:0]  id_i;
  logic             bit_tick_i;
  logic             bus_rx;
  logic             tx_o, busy_o, rx_only_o, won_o, lost_o, bit_err_o;
  logic [IDX_W-1:0] lost_idx_o;

  can_arb_node #(.ID_W(ID_W), .IDX_W(IDX_W)) u_can_arb_node (
    .clk(clk), .rst(rst), .start_i(start_i), .id_i(id_i),
    .bit_tick_i(bit_tick_i), .bus_rx_i(bus_rx),
    .tx_o(tx_o), .busy_o(busy_o), .rx_only_o(rx_only_o), .won_o(won_o),
    .lost_o(lost_o), .lost_idx_o(lost_idx_o), .bit_err_o(bit_err_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // Competing transmitters and a fault injector that pulls the bus recessive
  logic [ID_W-1:0] comp_id [NC];
  logic            comp_en [NC];
  logic            comp_alive [NC];
  logic            force_rec;

  // Behavioural model of the node under test
  logic            m_tx, m_busy, m_rxo, m_won, m_lost, m_err;
  int              m_idx, m_bit;
  logic [ID_W-1:0] m_id;
  logic            comp_drive;

  always_comb begin
    comp_drive = 1'b1;
    if (m_busy && m_bit >= 0 && m_bit < ID_W) begin
      for (int k = 0; k < NC; k++) begin
        if (comp_en[k] && comp_alive[k]) comp_drive = comp_drive & comp_id[k][m_bit];
      end
    end
    bus_rx = force_rec | (tx_o & comp_drive);
  end

  always @(posedge clk) begin
    if (rst) begin
      m_tx <= 1'b1; m_busy <= 1'b0; m_rxo <= 1'b0; m_won <= 1'b0;
      m_lost <= 1'b0; m_err <= 1'b0; m_idx <= 0; m_bit <= 0; m_id <= '0;
      for (int k = 0; k < NC; k++) comp_alive[k] <= 1'b1;
    end else if (!m_busy) begin
      if (start_i) begin
        m_busy <= 1'b1; m_id <= id_i; m_bit <= ID_W - 1; m_tx <= id_i[ID_W-1];
        m_won <= 1'b0; m_lost <= 1'b0; m_err <= 1'b0; m_idx <= 0;
        for (int k = 0; k < NC; k++) comp_alive[k] <= 1'b1;
      end
    end else if (bit_tick_i) begin
      for (int k = 0; k < NC; k++)
        if (comp_alive[k] && comp_id[k][m_bit] && !bus_rx) comp_alive[k] <= 1'b0;
      if (m_rxo) begin
        if (m_bit == 0) begin m_busy <= 1'b0; m_rxo <= 1'b0; end
        else m_bit <= m_bit - 1;
      end else if (m_tx && !bus_rx) begin
        m_lost <= 1'b1; m_idx <= m_bit; m_tx <= 1'b1;
        if (m_bit == 0) m_busy <= 1'b0;
        else begin m_rxo <= 1'b1; m_bit <= m_bit - 1; end
      end else if (!m_tx && bus_rx) begin
        m_err <= 1'b1; m_tx <= 1'b1; m_busy <= 1'b0;
      end else if (m_bit == 0) begin
        m_won <= 1'b1; m_tx <= 1'b1; m_busy <= 1'b0;
      end else begin
        m_bit <= m_bit - 1; m_tx <= m_id[m_bit-1];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison with the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(tx_o == m_tx,          "R2 tx_o vs model",       tx_o, m_tx);
      chk(busy_o == m_busy,      "R5 busy_o vs model",     busy_o, m_busy);
      chk(rx_only_o == m_rxo,    "R5 rx_only_o vs model",  rx_only_o, m_rxo);
      chk(won_o == m_won,        "R6 won_o vs model",      won_o, m_won);
      chk(lost_o == m_lost,      "R4 lost_o vs model",     lost_o, m_lost);
      chk(int'(lost_idx_o) == m_idx, "R4 lost_idx_o vs model", lost_idx_o, m_idx);
      chk(bit_err_o == m_err,    "R8 bit_err_o vs model",  bit_err_o, m_err);
    end
  end

  task automatic set_comps(input logic [ID_W-1:0] a, input bit ea,
                           input logic [ID_W-1:0] b, input bit eb,
                           input logic [ID_W-1:0] c, input bit ec);
    comp_id[0] = a; comp_en[0] = ea;
    comp_id[1] = b; comp_en[1] = eb;
    comp_id[2] = c; comp_en[2] = ec;
  endtask

  task automatic do_start(input logic [ID_W-1:0] id);
    @(negedge clk); start_i = 1'b1; id_i = id;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_tick(input int gap);
    bit_tick_i = 1'b1;
    @(negedge clk); bit_tick_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic run_field(input logic [ID_W-1:0] id, input int gap);
    do_start(id);
    for (int i = 0; i < ID_W; i++) do_tick(gap);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; id_i = '0; bit_tick_i = 1'b0; force_rec = 1'b0;
    set_comps('0, 1'b0, '0, 1'b0, '0, 1'b0);
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
    // R10: reset state
    chk(tx_o == 1'b1 && busy_o == 1'b0 && rx_only_o == 1'b0, "R10 reset tx/busy/rxo", {tx_o, busy_o, rx_only_o}, 3'b100);
    chk(!won_o && !lost_o && !bit_err_o && lost_idx_o == '0, "R10 reset flags", {won_o, lost_o, bit_err_o, lost_idx_o}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R11: strobes while idle
    do_tick(0); do_tick(1);
    chk(tx_o == 1'b1 && !busy_o && !won_o && !lost_o, "R11 idle strobes", {tx_o, busy_o, won_o, lost_o}, 4'b1000);

    // R1 / R3: a node alone, then against an identical identifier
    do_start(11'h5A3);
    chk(busy_o && tx_o == 1'b1 && !won_o, "R1 start loads MSB", {busy_o, tx_o, won_o}, 3'b110);
    for (int i = 0; i < ID_W; i++) do_tick(1);
    chk(won_o && !busy_o && tx_o, "R6 lone node wins", {won_o, busy_o, tx_o}, 3'b101);

    set_comps(11'h155, 1'b1, '0, 1'b0, '0, 1'b0);
    do_start(11'h155);
    chk(!won_o && busy_o && tx_o == 1'b0, "R1 start clears won, MSB 0", {won_o, busy_o, tx_o}, 3'b010);
    for (int i = 0; i < 5; i++) do_tick(0);
    chk(!lost_o && !bit_err_o && busy_o, "R3 matching bits continue", {lost_o, bit_err_o, busy_o}, 3'b001);
    for (int i = 0; i < 6; i++) do_tick(0);
    chk(won_o && !lost_o, "R3 equal identifiers both finish", {won_o, lost_o}, 2'b10);

    // R7 / R4: 0x2A5 against 0x2A3 loses at index 2
    set_comps(11'h2A3, 1'b1, '0, 1'b0, '0, 1'b0);
    run_field(11'h2A5, 0);
    chk(lost_o && !won_o, "R7 0x2A5 loses", {lost_o, won_o}, 2'b10);
    chk(int'(lost_idx_o) == 2, "R7 loss index", lost_idx_o, 2);

    // R7: the other way round
    set_comps(11'h2A5, 1'b1, '0, 1'b0, '0, 1'b0);
    run_field(11'h2A3, 2);
    chk(won_o && !lost_o, "R7 0x2A3 wins", {won_o, lost_o}, 2'b10);

    // R5: loss at the MSB, then listen for the rest of the field
    set_comps(11'h3FF, 1'b1, '0, 1'b0, '0, 1'b0);
    do_start(11'h7FF);
    do_tick(1);
    chk(lost_o && rx_only_o && busy_o && tx_o, "R5 rx-only after loss", {lost_o, rx_only_o, busy_o, tx_o}, 4'b1111);
    chk(int'(lost_idx_o) == 10, "R4 loss at MSB index", lost_idx_o, 10);
    for (int i = 0; i < ID_W - 2; i++) do_tick(0);
    chk(busy_o && rx_only_o, "R5 still busy before bit 0", {busy_o, rx_only_o}, 2'b11);
    do_tick(0);
    chk(!busy_o && !rx_only_o && lost_o, "R5 field ends after bit 0", {busy_o, rx_only_o, lost_o}, 3'b001);

    // R5: loss at the LSB ends at once
    set_comps(11'h000, 1'b1, '0, 1'b0, '0, 1'b0);
    run_field(11'h001, 0);
    chk(lost_o && int'(lost_idx_o) == 0 && !busy_o, "R5 loss at bit 0", lost_idx_o, 0);

    // R7: three competitors
    set_comps(11'h457, 1'b1, 11'h450, 1'b1, 11'h4FF, 1'b1);
    run_field(11'h456, 1);
    chk(lost_o && int'(lost_idx_o) == 2, "R7 three competitors loss index", lost_idx_o, 2);
    set_comps(11'h7FF, 1'b1, 11'h555, 1'b1, 11'h2A3, 1'b1);
    run_field(11'h000, 0);
    chk(won_o && !lost_o, "R7 lowest of four wins", {won_o, lost_o}, 2'b10);

    // R9: start in mid-field is ignored
    set_comps(11'h2A3, 1'b1, '0, 1'b0, '0, 1'b0);
    do_start(11'h2A5);
    for (int i = 0; i < 3; i++) do_tick(0);
    @(negedge clk); start_i = 1'b1; id_i = 11'h000;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o && !won_o, "R9 start while busy ignored", {busy_o, won_o}, 2'b10);
    for (int i = 0; i < ID_W - 3; i++) do_tick(0);
    chk(lost_o && int'(lost_idx_o) == 2, "R9 outcome from first identifier", lost_idx_o, 2);

    // R8: dominant sent, recessive read
    set_comps('0, 1'b0, '0, 1'b0, '0, 1'b0);
    force_rec = 1'b1;
    do_start(11'h3FF);
    do_tick(0);
    chk(bit_err_o && !lost_o && !busy_o && tx_o, "R8 bit error", {bit_err_o, lost_o, busy_o, tx_o}, 4'b1001);
    force_rec = 1'b0;
    for (int i = 0; i < 4; i++) do_tick(0);
    chk(bit_err_o && tx_o && !busy_o, "R11 strobes after error", {bit_err_o, tx_o, busy_o}, 3'b110);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule